// File: doc/BRIEF.md
# I/O Control Register Block with Network Interrupt Aggregation

This block is a small memory-mapped register file for a router I/O controller. A synchronous bus (enable, write strobe, offset, write data) reaches a sparse register map. One read-only register reports which interface cards are plugged in. A read/write register holds the card-select value that steers serial EEPROM access, and that value is also driven out on a port. One register always reads as all ones. One offset is a harmless placeholder. Any other offset reads as zero and raises a sticky flag.

Next to the register file sits an 8-bit network interrupt status vector. Each source sends set and clear pulses that name a slot and a port. The bit these update is the slot's base index plus the port number, and slot 0 has base 0. The vector drives a single level interrupt that is high whenever any bit is set. Both the vector and the interrupt are registered.

Top module: `ioctl_regfile`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), bus_rdata, card_sel, net_status, net_irq and undec_seen are all zero.
- R2: A read (bus_en=1, bus_we=0) loads bus_rdata at the clock edge that samples it. bus_rdata then holds that value through cycles with no read.
- R3: Offset 0x10 is the presence register and is read-only. Bit 1 equals card_present[0], bit 2 equals card_present[1], and all other bits read 0. Writes to it change nothing.
- R4: Offset 0x18 is the card-select register. A write loads bus_wdata into it at the sampling edge. A read returns the last value written. card_sel always shows its contents.
- R5: Offset 0x4C always reads 0xFF. Writes to it leave every output unchanged.
- R6: Offset 0x04 accepts reads and writes with no effect. A read returns 0, card_sel is unchanged and undec_seen is not set.
- R7: A set pulse (net_set_vld=1) sets bit net_set_slot*8+net_set_port of net_status at the sampling edge. Other bits keep their values.
- R8: A clear pulse (net_clr_vld=1) clears bit net_clr_slot*8+net_clr_port at the sampling edge.
- R9: If a set and a clear name the same bit in the same cycle, the bit ends up set. If they name different bits, both take effect.
- R10: net_irq is 1 exactly when net_status is non-zero. It changes at the same edge as the status vector, one cycle after the pulse is presented.
- R11: A read or write to any offset other than 0x04, 0x10, 0x18 and 0x4C returns 0 when read and changes no register. It sets undec_seen, which stays 1 until reset.
- R12: A set or clear whose slot is 1 or more (outside the single configured slot) leaves net_status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| card_present | input | 2 | Card presence for interface slots 0 and 1 |
| card_sel | output | 8 | Card-select register contents |
| net_set_vld | input | 1 | Set pulse for one status bit |
| net_set_slot | input | 1 | Slot of the set pulse |
| net_set_port | input | 3 | Port of the set pulse |
| net_clr_vld | input | 1 | Clear pulse for one status bit |
| net_clr_slot | input | 1 | Slot of the clear pulse |
| net_clr_port | input | 3 | Port of the clear pulse |
| net_status | output | 8 | Network interrupt status vector |
| net_irq | output | 1 | Level interrupt, OR of the status vector |
| undec_seen | output | 1 | Sticky flag for an access to an undecoded offset |

## Verification
Every result of this block lands at the single clock edge that samples the stimulus. Read data, card_sel, the status vector, net_irq and the sticky flag all update at that edge, with no extra pipeline stage. The bench drives each request just after a falling edge, waits for the next rising edge, and samples one nanosecond later, while the strobe is still asserted. Checks that something was ignored, or that a value is held, are sampled again after a following read or an idle cycle. This shows the state did not move.

// File: rtl/ioctl_pkg.sv
package ioctl_pkg;

    // Offsets the register map decodes
    localparam int OFF_NOP   = 'h04;
    localparam int OFF_PRES  = 'h10;
    localparam int OFF_CSEL  = 'h18;
    localparam int OFF_FIXED = 'h4C;

    // Bit positions of the two presence indications
    localparam int PRES_BIT_S0 = 1;
    localparam int PRES_BIT_S1 = 2;

    typedef enum logic [2:0] {
        SEL_NOP,
        SEL_PRES,
        SEL_CSEL,
        SEL_FIXED,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/ioctl_decode.sv
module ioctl_decode
    import ioctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] A_NOP   = ADDR_W'(OFF_NOP);
    localparam logic [ADDR_W-1:0] A_PRES  = ADDR_W'(OFF_PRES);
    localparam logic [ADDR_W-1:0] A_CSEL  = ADDR_W'(OFF_CSEL);
    localparam logic [ADDR_W-1:0] A_FIXED = ADDR_W'(OFF_FIXED);

    always_comb begin
        unique case (addr)
            A_NOP:   sel = SEL_NOP;
            A_PRES:  sel = SEL_PRES;
            A_CSEL:  sel = SEL_CSEL;
            A_FIXED: sel = SEL_FIXED;
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/ioctl_irqvec.sv
module ioctl_irqvec #(
    parameter int NIRQ_W    = 8,
    parameter int NSLOT     = 1,
    parameter int PORTS     = 8,
    localparam int SLOT_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int PORT_W   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic [PORT_W-1:0] set_port,
    input  logic              clr_vld,
    input  logic [SLOT_W-1:0] clr_slot,
    input  logic [PORT_W-1:0] clr_port,
    output logic [NIRQ_W-1:0] status,
    output logic              irq
);

    localparam int IDX_W = SLOT_W + PORT_W + 1;

    typedef struct packed {
        logic [NIRQ_W-1:0] vec;
        logic              irq;
    } vec_st_t;

    vec_st_t st_d, st_q;

    logic [IDX_W-1:0]  set_idx, clr_idx;
    logic              set_ok, clr_ok;
    logic [NIRQ_W-1:0] set_oh, clr_oh;

    // Bit index = slot base (slot * PORTS) + port; slot 0 starts at bit 0
    always_comb begin
        set_idx = IDX_W'(set_slot) * IDX_W'(PORTS) + IDX_W'(set_port);
        clr_idx = IDX_W'(clr_slot) * IDX_W'(PORTS) + IDX_W'(clr_port);
        set_ok  = set_vld && (int'(set_slot) < NSLOT) && (int'(set_idx) < NIRQ_W);
        clr_ok  = clr_vld && (int'(clr_slot) < NSLOT) && (int'(clr_idx) < NIRQ_W);
    end

    // One-hot request vectors, one bit per status position
    for (genvar b = 0; b < NIRQ_W; b++) begin : g_oh
        assign set_oh[b] = set_ok && (int'(set_idx) == b);
        assign clr_oh[b] = clr_ok && (int'(clr_idx) == b);
    end

    always_comb begin
        st_d     = st_q;
        // clear first, then set, so a set on the same bit wins
        st_d.vec = (st_q.vec & ~clr_oh) | set_oh;
        st_d.irq = |st_d.vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.vec;
    assign irq    = st_q.irq;

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_oh) |=> ((status & $past(set_oh)) == $past(set_oh)));

    a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_oh & ~set_oh)) |=> ((status & $past(clr_oh & ~set_oh)) == '0));

    a_r10_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set_vld));

    a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ok && !clr_ok) |=> $stable(status));

endmodule

// File: rtl/ioctl_regfile.sv
module ioctl_regfile
    import ioctl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int NIRQ_W  = 8,
    parameter int NSLOT   = 1,
    parameter int PORTS   = 8,
    parameter logic [DATA_W-1:0] FIXED_VAL = '1,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        card_present,
    output logic [DATA_W-1:0] card_sel,
    input  logic              net_set_vld,
    input  logic [SLOT_W-1:0] net_set_slot,
    input  logic [PORT_W-1:0] net_set_port,
    input  logic              net_clr_vld,
    input  logic [SLOT_W-1:0] net_clr_slot,
    input  logic [PORT_W-1:0] net_clr_port,
    output logic [NIRQ_W-1:0] net_status,
    output logic              net_irq,
    output logic              undec_seen
);

    typedef struct packed {
        logic [DATA_W-1:0] csel;
        logic [DATA_W-1:0] rdata;
        logic              undec;
    } reg_st_t;

    reg_st_t  st_d, st_q;
    reg_sel_e sel;
    logic     rd, wr;
    logic [DATA_W-1:0] pres_word;

    ioctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    ioctl_irqvec #(
        .NIRQ_W (NIRQ_W),
        .NSLOT  (NSLOT),
        .PORTS  (PORTS)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (net_set_vld),
        .set_slot (net_set_slot),
        .set_port (net_set_port),
        .clr_vld  (net_clr_vld),
        .clr_slot (net_clr_slot),
        .clr_port (net_clr_port),
        .status   (net_status),
        .irq      (net_irq)
    );

    assign rd = bus_en && !bus_we;
    assign wr = bus_en &&  bus_we;

    always_comb begin
        pres_word              = '0;
        pres_word[PRES_BIT_S0] = card_present[0];
        pres_word[PRES_BIT_S1] = card_present[1];
    end

    always_comb begin
        st_d = st_q;
        if (rd) begin
            unique case (sel)
                SEL_PRES:  st_d.rdata = pres_word;
                SEL_CSEL:  st_d.rdata = st_q.csel;
                SEL_FIXED: st_d.rdata = FIXED_VAL;
                default:   st_d.rdata = '0;
            endcase
        end
        if (wr && sel == SEL_CSEL) st_d.csel = bus_wdata;
        if (bus_en && sel == SEL_NONE) st_d.undec = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign card_sel   = st_q.csel;
    assign undec_seen = st_q.undec;

    a_r4_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_CSEL) |=> (card_sel == $past(bus_wdata)));

    a_r4_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == SEL_CSEL) |=> $stable(card_sel));

    a_r5_fixed_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_FIXED) |=> (bus_rdata == FIXED_VAL));

    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        undec_seen |=> undec_seen);

endmodule

// File: tb/sim_ioctl_regfile.sv
`timescale 1ns/1ps
module sim_ioctl_regfile;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_en, bus_we;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0] card_present;
    logic [7:0] card_sel;
    logic       net_set_vld, net_clr_vld;
    logic [0:0] net_set_slot, net_clr_slot;
    logic [2:0] net_set_port, net_clr_port;
    logic [7:0] net_status;
    logic       net_irq, undec_seen;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ioctl_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .card_present(card_present), .card_sel(card_sel),
        .net_set_vld(net_set_vld), .net_set_slot(net_set_slot), .net_set_port(net_set_port),
        .net_clr_vld(net_clr_vld), .net_clr_slot(net_clr_slot), .net_clr_port(net_clr_port),
        .net_status(net_status), .net_irq(net_irq), .undec_seen(undec_seen)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        net_set_vld = 0; net_set_slot = 0; net_set_port = 0;
        net_clr_vld = 0; net_clr_slot = 0; net_clr_port = 0;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        @(negedge clk);
        idle_inputs();
    endtask

    // one cycle of set and/or clear requests; results sampled just after the edge
    task automatic net_pulse(input logic sv, input logic ss, input logic [2:0] sp,
                             input logic cv, input logic cs, input logic [2:0] cp);
        @(negedge clk);
        net_set_vld = sv; net_set_slot = ss; net_set_port = sp;
        net_clr_vld = cv; net_clr_slot = cs; net_clr_port = cp;
        @(posedge clk); #1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        check("R1 rdata", bus_rdata, 0);
        check("R1 card_sel", card_sel, 0);
        check("R1 net_status", net_status, 0);
        check("R1 net_irq", net_irq, 0);
        check("R1 undec_seen", undec_seen, 0);
    endtask

    task automatic t_presence();
        logic [7:0] d;
        card_present = 2'b01; bus_rd(8'h10, d); check("R3 slot0 present", d, 8'h02);
        card_present = 2'b10; bus_rd(8'h10, d); check("R3 slot1 present", d, 8'h04);
        card_present = 2'b11; bus_rd(8'h10, d); check("R3 both present", d, 8'h06);
        bus_wr(8'h10, 8'hFF);
        bus_rd(8'h10, d); check("R3 write ignored", d, 8'h06);
        check("R3 card_sel untouched", card_sel, 0);
        card_present = 2'b00; bus_rd(8'h10, d); check("R3 none present", d, 8'h00);
    endtask

    task automatic t_select();
        logic [7:0] d;
        bus_wr(8'h18, 8'hA5);
        check("R4 card_sel after write", card_sel, 8'hA5);
        bus_rd(8'h18, d); check("R4 readback A5", d, 8'hA5);
        bus_wr(8'h18, 8'h3C);
        bus_rd(8'h18, d); check("R4 readback 3C", d, 8'h3C);
        // R2: read data holds through idle and write cycles
        bus_wr(8'h18, 8'h20);
        repeat (2) @(posedge clk);
        #1 check("R2 rdata held", bus_rdata, 8'h3C);
        check("R4 card_sel 20", card_sel, 8'h20);
    endtask

    task automatic t_fixed();
        logic [7:0] d;
        bus_rd(8'h4C, d); check("R5 fixed read", d, 8'hFF);
        bus_wr(8'h4C, 8'h00);
        bus_rd(8'h4C, d); check("R5 fixed after write", d, 8'hFF);
        check("R5 card_sel untouched", card_sel, 8'h20);
        check("R5 no undec", undec_seen, 0);
    endtask

    task automatic t_nop();
        logic [7:0] d;
        bus_wr(8'h04, 8'h77);
        bus_rd(8'h04, d); check("R6 read zero", d, 8'h00);
        check("R6 card_sel untouched", card_sel, 8'h20);
        check("R6 no undec", undec_seen, 0);
    endtask

    task automatic t_irq();
        net_pulse(1, 0, 3'd3, 0, 0, 0);
        check("R7 set bit3", net_status, 8'h08);
        check("R10 irq high", net_irq, 1);
        net_pulse(1, 0, 3'd0, 0, 0, 0);
        check("R7 set bit0", net_status, 8'h09);
        net_pulse(0, 0, 0, 1, 0, 3'd3);
        check("R8 clear bit3", net_status, 8'h01);
        check("R10 irq still high", net_irq, 1);
        net_pulse(0, 0, 0, 1, 0, 3'd0);
        check("R8 clear bit0", net_status, 8'h00);
        check("R10 irq low", net_irq, 0);
        net_pulse(1, 0, 3'd5, 1, 0, 3'd5);
        check("R9 same bit set wins", net_status, 8'h20);
        net_pulse(1, 0, 3'd2, 1, 0, 3'd5);
        check("R9 different bits", net_status, 8'h04);
        net_pulse(1, 1, 3'd0, 0, 0, 0);
        check("R12 set slot1 ignored", net_status, 8'h04);
        net_pulse(0, 0, 0, 1, 1, 3'd2);
        check("R12 clear slot1 ignored", net_status, 8'h04);
        net_pulse(1, 0, 3'd7, 0, 0, 0);
        check("R7 set bit7", net_status, 8'h84);
        net_pulse(0, 0, 0, 1, 0, 3'd7);
        net_pulse(0, 0, 0, 1, 0, 3'd2);
        check("R10 all clear", net_irq, 0);
        check("R8 empty", net_status, 8'h00);
    endtask

    task automatic t_undecoded();
        logic [7:0] d;
        bus_rd(8'h18, d);
        bus_rd(8'h20, d); check("R11 undecoded reads zero", d, 8'h00);
        check("R11 flag set", undec_seen, 1);
        bus_wr(8'h30, 8'h55);
        check("R11 write ignored", card_sel, 8'h20);
        bus_rd(8'h4C, d);
        check("R11 flag sticky", undec_seen, 1);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        card_present = 2'b00;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(posedge clk); #1;
        t_reset();
        t_presence();
        t_select();
        t_fixed();
        t_nop();
        t_irq();
        t_undecoded();
        // R1 again: reset clears everything set above
        @(negedge clk); rst_n = 0; net_set_vld = 1; net_set_port = 3'd1;
        @(posedge clk); #1;
        @(negedge clk); rst_n = 1; idle_inputs();
        @(posedge clk); #1;
        check("R1 card_sel cleared", card_sel, 0);
        check("R1 undec cleared", undec_seen, 0);
        check("R1 status cleared", net_status, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule